// File: doc/BRIEF.md
# Timer-Triggered Multi-Sequencer Sample FIFO

This block is the digital side of a four-channel conversion front end. Each of the four sample sequencers owns a 16-deep result FIFO and an interrupt line. A pulse on the timer trigger input makes every sequencer that is enabled, and whose 4-bit event selector holds the timer code, take one sample. The samples come from a linear-congruential noise generator that stands in for a real converter. Each sample is written into that sequencer's FIFO and sets its raw interrupt bit.

Software talks to the block over a simple register port. A write is qualified by `wr_en`, and a read by `rd_en`. Read data is combinational from the address. A read of a FIFO pop address returns the oldest entry and removes it at the clock edge that ends the read. Each sequencer also has a status word. It packs the read pointer, write pointer, empty flag and full flag, so that software can poll the FIFO fill level in one access.

Top module: `adc_seq_fifo_top`

## Requirements
- R1: Each of the four sequencers stores samples in a 16-entry FIFO, and pops through its pop address return them oldest first.
- R2: The per-sequencer status word holds the read pointer in bits 3:0, the write pointer in bits 7:4, empty in bit 8 and full in bit 12; after reset every status word reads 0x100 and empty and full are never both set.
- R3: A sample taken while the FIFO is full is dropped and leaves the status word unchanged; a pop of an empty FIFO leaves the status word unchanged.
- R4: A pop clears full and sets empty when the new read pointer equals the write pointer; a push clears empty and sets full when the new write pointer equals the read pointer.
- R5: On a trigger pulse, sequencer n takes a sample only if enable bit n is set and event-select field bits 4n+3:4n equal 5; otherwise its FIFO is untouched.
- R6: The noise state, reset to 0, advances as state*314159+1 (mod 2^32) once per sample taken, even if the sample is dropped, visiting sequencers in ascending order within one trigger; the stored sample is 0x200 plus bits 18:16 of the advanced state.
- R7: Register map: enable at 0x00 (4 bits kept), raw status at 0x04 (read only), mask at 0x08 (4 bits), clear at 0x0C, event select at 0x14 (16 bits kept); per sequencer n at 0x40+0x20n: mux at +0x00 (write masked with 0x33333333), control at +0x04 (32 bits kept), pop at +0x08, status at +0x0C.
- R8: A sample taken by sequencer n sets raw bit n; writing 1 to bit n at 0x0C clears it, and a take in the same cycle wins over the clear.
- R9: Interrupt output n equals raw bit n AND mask bit n, and a read of 0x0C returns raw AND mask.
- R10: When a pop and a take of the same sequencer coincide, the pop is applied first and the push second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops on a pop address) |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| trig_i | input | 1 | Timer trigger pulse, one cycle per event |
| irq_o | output | 4 | Per-sequencer interrupt lines |

## Verification
The hardest case to reach is a pop and a timer take that land on the same sequencer in the same cycle. This case is run against both an empty FIFO and a one-entry FIFO. The bench gets there by raising `rd_en` on the pop address and `trig_i` in the same drive slot. A second hard state is a FIFO that is full, with the read pointer away from zero. The bench produces it by first pushing and popping one entry, and then issuing sixteen triggers. A seventeenth trigger confirms the drop, and the noise model stays in step with the hidden state advance.

// File: rtl/adc_pkg.sv
package adc_pkg;
    localparam int N_SEQ_DEF    = 4;
    localparam int DEPTH_DEF    = 16;
    localparam int SAMPLE_W_DEF = 10;

    localparam logic [3:0]  EVT_TIMER   = 4'd5;
    localparam logic [31:0] LCG_MUL     = 32'd314159;
    localparam logic [31:0] LCG_INC     = 32'd1;
    localparam int          SAMPLE_BASE = 'h200;
    localparam int          NOISE_LSB   = 16;
    localparam logic [31:0] MUX_KEEP    = 32'h3333_3333;

    localparam int A_ENABLE = 'h00;
    localparam int A_RAW    = 'h04;
    localparam int A_MASK   = 'h08;
    localparam int A_CLEAR  = 'h0C;
    localparam int A_EMUX   = 'h14;

    localparam int SEQ_BASE   = 'h40;
    localparam int SEQ_STRIDE = 'h20;
    localparam int OFF_MUX    = 'h00;
    localparam int OFF_CTL    = 'h04;
    localparam int OFF_POP    = 'h08;
    localparam int OFF_STAT   = 'h0C;

    localparam int ST_WR_LSB    = 4;
    localparam int ST_EMPTY_BIT = 8;
    localparam int ST_FULL_BIT  = 12;
endpackage

// File: rtl/adc_fifo.sv
module adc_fifo
    import adc_pkg::*;
#(
    parameter int DEPTH    = DEPTH_DEF,
    parameter int SAMPLE_W = SAMPLE_W_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push,
    input  logic                pop,
    input  logic [SAMPLE_W-1:0] push_data,
    output logic [SAMPLE_W-1:0] head_data,
    output logic [31:0]         status
);
    localparam int PTR_W = $clog2(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic             empty;
        logic             full;
    } fifo_st_t;

    fifo_st_t            s_d, s_q;
    logic [SAMPLE_W-1:0] mem_d [DEPTH];
    logic [SAMPLE_W-1:0] mem_q [DEPTH];

    always_comb begin
        s_d   = s_q;
        mem_d = mem_q;
        // pop first, then push
        if (pop && !s_q.empty) begin
            s_d.rd    = s_q.rd + PTR_W'(1);
            s_d.full  = 1'b0;
            s_d.empty = (s_d.rd == s_q.wr);
        end
        if (push && !s_d.full) begin
            mem_d[s_q.wr] = push_data;
            s_d.wr        = s_q.wr + PTR_W'(1);
            s_d.empty     = 1'b0;
            s_d.full      = (s_d.wr == s_d.rd);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{rd: '0, wr: '0, empty: 1'b1, full: 1'b0};
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            s_q   <= s_d;
            mem_q <= mem_d;
        end
    end

    assign head_data = mem_q[s_q.rd];

    always_comb begin
        status                       = '0;
        status[PTR_W-1:0]            = s_q.rd;
        status[ST_WR_LSB +: PTR_W]   = s_q.wr;
        status[ST_EMPTY_BIT]         = s_q.empty;
        status[ST_FULL_BIT]          = s_q.full;
    end
endmodule

// File: rtl/adc_noise_chain.sv
module adc_noise_chain
    import adc_pkg::*;
#(
    parameter int NSEQ     = N_SEQ_DEF,
    parameter int SAMPLE_W = SAMPLE_W_DEF
) (
    input  logic [31:0]                    seed,
    input  logic [NSEQ-1:0]                take,
    output logic [31:0]                    state_out,
    output logic [NSEQ-1:0][SAMPLE_W-1:0]  sample
);
    logic [31:0] cur;
    logic [31:0] nxt;

    always_comb begin
        cur = seed;
        nxt = '0;
        for (int n = 0; n < NSEQ; n++) begin
            nxt       = cur * LCG_MUL + LCG_INC;
            sample[n] = SAMPLE_W'(SAMPLE_BASE) + SAMPLE_W'(nxt[NOISE_LSB +: 3]);
            if (take[n]) cur = nxt;
        end
        state_out = cur;
    end
endmodule

// File: rtl/adc_seq_fifo_top.sv
module adc_seq_fifo_top
    import adc_pkg::*;
#(
    parameter int NSEQ     = N_SEQ_DEF,
    parameter int DEPTH    = DEPTH_DEF,
    parameter int SAMPLE_W = SAMPLE_W_DEF,
    parameter int ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              trig_i,
    output logic [NSEQ-1:0]   irq_o
);
    localparam int EMUX_W = 4 * NSEQ;

    typedef struct packed {
        logic [NSEQ-1:0]        enable;
        logic [NSEQ-1:0]        raw;
        logic [NSEQ-1:0]        mask;
        logic [EMUX_W-1:0]      emux;
        logic [31:0]            noise;
        logic [NSEQ-1:0][31:0]  smux;
        logic [NSEQ-1:0][31:0]  sctl;
    } regs_t;

    regs_t                        r_d, r_q;
    logic [NSEQ-1:0]              take, pop, clr;
    logic [NSEQ-1:0][31:0]        seq_status;
    logic [NSEQ-1:0][SAMPLE_W-1:0] head, sample;
    logic [31:0]                  noise_next;

    function automatic logic [ADDR_W-1:0] seq_addr(input int n, input int off);
        return ADDR_W'(SEQ_BASE + n * SEQ_STRIDE + off);
    endfunction

    function automatic logic [ADDR_W-1:0] glb_addr(input int a);
        return ADDR_W'(a);
    endfunction

    always_comb begin
        for (int n = 0; n < NSEQ; n++) begin
            take[n] = trig_i && r_q.enable[n] && (r_q.emux[4*n +: 4] == EVT_TIMER);
            pop[n]  = rd_en && (addr == seq_addr(n, OFF_POP));
        end
        clr = (wr_en && addr == glb_addr(A_CLEAR)) ? wdata[NSEQ-1:0] : '0;
    end

    adc_noise_chain #(.NSEQ(NSEQ), .SAMPLE_W(SAMPLE_W)) noise_i (
        .seed      (r_q.noise),
        .take      (take),
        .state_out (noise_next),
        .sample    (sample)
    );

    for (genvar g = 0; g < NSEQ; g++) begin : g_seq
        adc_fifo #(.DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W)) fifo_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (take[g]),
            .pop       (pop[g]),
            .push_data (sample[g]),
            .head_data (head[g]),
            .status    (seq_status[g])
        );
    end

    always_comb begin
        r_d       = r_q;
        r_d.noise = noise_next;
        if (wr_en) begin
            if (addr == glb_addr(A_ENABLE)) r_d.enable = wdata[NSEQ-1:0];
            if (addr == glb_addr(A_MASK))   r_d.mask   = wdata[NSEQ-1:0];
            if (addr == glb_addr(A_EMUX))   r_d.emux   = wdata[EMUX_W-1:0];
            for (int n = 0; n < NSEQ; n++) begin
                if (addr == seq_addr(n, OFF_MUX)) r_d.smux[n] = wdata & MUX_KEEP;
                if (addr == seq_addr(n, OFF_CTL)) r_d.sctl[n] = wdata;
            end
        end
        r_d.raw = (r_q.raw & ~clr) | take;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign irq_o = r_q.raw & r_q.mask;

    always_comb begin
        rdata = '0;
        if (addr == glb_addr(A_ENABLE)) rdata = 32'(r_q.enable);
        if (addr == glb_addr(A_RAW))    rdata = 32'(r_q.raw);
        if (addr == glb_addr(A_MASK))   rdata = 32'(r_q.mask);
        if (addr == glb_addr(A_CLEAR))  rdata = 32'(r_q.raw & r_q.mask);
        if (addr == glb_addr(A_EMUX))   rdata = 32'(r_q.emux);
        for (int n = 0; n < NSEQ; n++) begin
            if (addr == seq_addr(n, OFF_MUX))  rdata = r_q.smux[n];
            if (addr == seq_addr(n, OFF_CTL))  rdata = r_q.sctl[n];
            if (addr == seq_addr(n, OFF_POP))  rdata = 32'(head[n]);
            if (addr == seq_addr(n, OFF_STAT)) rdata = seq_status[n];
        end
    end
endmodule

// File: rtl/adc_seq_fifo_chk.sv
module adc_seq_fifo_chk
    import adc_pkg::*;
#(
    parameter int NSEQ   = N_SEQ_DEF,
    parameter int ADDR_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  trig_i,
    input logic                  wr_en,
    input logic                  rd_en,
    input logic [ADDR_W-1:0]     addr,
    input logic [31:0]           wdata,
    input logic [NSEQ-1:0]       irq_o,
    input logic [NSEQ-1:0]       en,
    input logic [NSEQ-1:0][31:0] seq_status
);
    for (genvar g = 0; g < NSEQ; g++) begin : g_chk
        logic pop_g;
        assign pop_g = rd_en && (addr == ADDR_W'(SEQ_BASE + g * SEQ_STRIDE + OFF_POP));

        AST_NOT_EMPTY_AND_FULL: assert property (@(posedge clk) disable iff (!rst_n)
            !(seq_status[g][ST_EMPTY_BIT] && seq_status[g][ST_FULL_BIT])); // R2

        AST_NO_PUSH_WITHOUT_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
            !trig_i |=> $stable(seq_status[g][ST_WR_LSB +: 4])); // R5

        AST_NO_PUSH_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
            !en[g] |=> $stable(seq_status[g][ST_WR_LSB +: 4])); // R5

        AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (pop_g && seq_status[g][ST_EMPTY_BIT] && !trig_i) |=> $stable(seq_status[g])); // R3

        AST_FULL_DROP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (seq_status[g][ST_FULL_BIT] && !pop_g) |=> $stable(seq_status[g])); // R3
    end

    AST_CLEAR_ALL_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(A_CLEAR) && wdata[NSEQ-1:0] == '1 && !trig_i)
        |=> (irq_o == '0)); // R8
endmodule

bind adc_seq_fifo_top adc_seq_fifo_chk #(.NSEQ(NSEQ), .ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_i     (trig_i),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .irq_o      (irq_o),
    .en         (r_q.enable),
    .seq_status (seq_status)
);

// File: tb/adc_seq_fifo_tb.sv
module adc_seq_fifo_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, trig_i = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  irq_o;

    int checks = 0;
    int errors = 0;

    logic [31:0] nz;
    logic [3:0]  sh_en;
    logic [15:0] sh_emux;
    logic [9:0]  mq [4][$];

    always #10 clk = ~clk;

    adc_seq_fifo_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .trig_i(trig_i), .irq_o(irq_o)
    );

    // is_wr, addr, wdata, expected read
    localparam int NV = 14;
    localparam logic [72:0] VEC [NV] = '{
        {1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 8'h00, 32'h0,         32'h0000_000F},
        {1'b1, 8'h40, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 8'h40, 32'h0,         32'h3333_3333},
        {1'b1, 8'hA0, 32'h1234_5678, 32'h0},
        {1'b0, 8'hA0, 32'h0,         32'h1230_1230},
        {1'b1, 8'h64, 32'hDEAD_BEEF, 32'h0},
        {1'b0, 8'h64, 32'h0,         32'hDEAD_BEEF},
        {1'b1, 8'h08, 32'h0000_005A, 32'h0},
        {1'b0, 8'h08, 32'h0,         32'h0000_000A},
        {1'b1, 8'h14, 32'h1234_5670, 32'h0},
        {1'b0, 8'h14, 32'h0,         32'h0000_5670},
        {1'b1, 8'h04, 32'h0000_000F, 32'h0},
        {1'b0, 8'h04, 32'h0,         32'h0}
    };

    function automatic logic [31:0] lcg(input logic [31:0] x);
        return x * 32'd314159 + 32'd1;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic model_trig();
        for (int n = 0; n < 4; n++) begin
            if (sh_en[n] && sh_emux[4*n +: 4] == 4'd5) begin
                nz = lcg(nz);
                if (mq[n].size() < 16) mq[n].push_back(10'h200 + 10'(nz[18:16]));
            end
        end
    endtask

    // one bus cycle; rdata sampled before the edge
    task automatic cyc(input logic w, input logic r, input logic t, input logic [7:0] a,
                       input logic [31:0] d, output logic [31:0] q);
        @(negedge clk);
        wr_en = w; rd_en = r; trig_i = t; addr = a; wdata = d;
        #1 q = rdata;
        @(posedge clk);
        if (w && a == 8'h00) sh_en = d[3:0];
        if (w && a == 8'h14) sh_emux = d[15:0];
        if (t) model_trig();
        @(negedge clk);
        wr_en = 0; rd_en = 0; trig_i = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] q;
        cyc(1, 0, 0, a, d, q);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] q);
        cyc(0, 1, 0, a, 32'h0, q);
    endtask

    task automatic trig();
        logic [31:0] q;
        cyc(0, 0, 1, 8'h00, 32'h0, q);
    endtask

    task automatic pop_chk(input int n, input string req);
        logic [31:0] q;
        logic [9:0]  e;
        e = mq[n].pop_front();
        rd(8'(8'h48 + n * 8'h20), q);
        chk(req, q, 32'(e));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        nz = 0; sh_en = 0; sh_emux = 0;
        for (int n = 0; n < 4; n++) mq[n].delete();
    endtask

    initial begin
        #(20 * 200000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] q;
        do_reset();

        // R2 reset state
        for (int n = 0; n < 4; n++) begin
            rd(8'(8'h4C + n * 8'h20), q);
            chk("R2 reset status", q, 32'h100);
        end
        rd(8'h04, q); chk("R7 reset raw", q, 0);
        #1 chk("R9 reset irq", 32'(irq_o), 0);

        // R7 register table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
            else begin
                rd(VEC[i][71:64], q);
                chk("R7 register", q, VEC[i][31:0]);
            end
        end

        // R5/R6/R8/R9 single sequencer take
        do_reset();
        wr(8'h14, 32'h5); wr(8'h00, 32'h1); wr(8'h08, 32'h1);
        trig();
        rd(8'h4C, q); chk("R4 status after push", q, 32'h010);
        rd(8'h6C, q); chk("R5 seq1 untouched", q, 32'h100);
        rd(8'h04, q); chk("R8 raw set", q, 32'h1);
        #1 chk("R9 irq high", 32'(irq_o), 32'h1);
        rd(8'h0C, q); chk("R9 masked read", q, 32'h1);
        pop_chk(0, "R6 first sample");
        rd(8'h4C, q); chk("R4 empty after pop", q, 32'h111);

        // R5 field mismatch and disabled sequencer
        wr(8'h14, 32'h4); trig();
        rd(8'h4C, q); chk("R5 field 4 ignored", q, 32'h111);
        wr(8'h14, 32'h5); wr(8'h00, 32'h0); trig();
        rd(8'h4C, q); chk("R5 disabled ignored", q, 32'h111);

        // R8 clear
        wr(8'h0C, 32'h1);
        rd(8'h04, q); chk("R8 raw cleared", q, 32'h0);
        #1 chk("R9 irq low", 32'(irq_o), 32'h0);

        // R3/R4 fill, overflow drop, drain, empty pop
        wr(8'h00, 32'h1);
        for (int i = 0; i < 16; i++) trig();
        rd(8'h4C, q); chk("R4 full status", q, 32'h1011);
        trig();
        rd(8'h4C, q); chk("R3 drop when full", q, 32'h1011);
        for (int i = 0; i < 16; i++) pop_chk(0, "R1 fifo order");
        rd(8'h4C, q); chk("R4 drained status", q, 32'h111);
        rd(8'h48, q);
        rd(8'h4C, q); chk("R3 empty pop holds", q, 32'h111);

        // R6 ordering across sequencers, noise continues after drop
        wr(8'h14, 32'h0505); wr(8'h00, 32'h5);
        trig();
        pop_chk(0, "R6 seq0 sample");
        pop_chk(2, "R6 seq2 sample");

        // R8 take wins over clear in the same cycle
        cyc(1, 0, 1, 8'h0C, 32'hF, q);
        rd(8'h04, q); chk("R8 set wins", q, 32'h5);
        wr(8'h0C, 32'hF);
        rd(8'h04, q); chk("R8 clear all", q, 32'h0);

        // R10 pop and take together: seq0 currently has one entry, seq2 one
        pop_chk(2, "R1 seq2 drain");
        pop_chk(0, "R1 seq0 drain");
        rd(8'h4C, q); chk("R10 pre status", q, 32'h133);
        cyc(0, 1, 1, 8'h48, 32'h0, q);  // empty pop + take
        rd(8'h4C, q); chk("R10 empty pop plus push", q, 32'h043);
        begin
            logic [9:0] e;
            e = mq[0][0];
            cyc(0, 1, 1, 8'h48, 32'h0, q);  // one-entry pop + take
            chk("R10 popped value", q, 32'(e));
            void'(mq[0].pop_front());
        end
        rd(8'h4C, q); chk("R10 pop plus push", q, 32'h054);
        pop_chk(0, "R6 sample after concurrent push");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule